// File: doc/BRIEF.md
# CAN Receive Mailbox Match and Store Selector

This block decides where a frame arriving from a CAN controller's receive path is stored. It takes the frame's identifier, its IDE (extended format) flag and a tag saying that this node sent the frame itself. It also takes the identifier, IDE flag, acceptance mask and status code of every message buffer, plus a set of shared masks. Each status code already names a receive buffer as empty, full or overrun. From these inputs the block picks one buffer, states that buffer's new status code, and raises a one-cycle store strobe together with a receive interrupt request. The buffer RAM, bit timing and frame decoding all sit outside the block.

A compatibility bit chooses between two policies. When the bit is clear, one shared mask serves most buffers, the two buffers at the top of the default map have masks of their own, and the first buffer that matches always takes the frame, even if it still holds an unread one. When the bit is set, every buffer has its own mask, and buffers that are occupied are skipped in favour of the next matching empty one. A second bit can stop the node from storing frames it sent itself. Both bits clear on reset, and a write to them takes effect only while the controller is frozen.

Top module: `rx_slot_selector`

## Requirements
- R1: Buffer i matches a frame when three things hold. Its status code is a receive code: 4'b0100 empty, 4'b0010 full or 4'b0110 overrun. Its IDE flag equals the frame's. And ((rx_id XOR id_i) AND mask_i) is zero over bits [10:0] for a standard frame (IDE=0) or over bits [28:0] for an extended frame (IDE=1).
- R2: With the compatibility bit at 0, buffer SPEC_A (14) uses the mask `mask_a`, buffer SPEC_B (15) uses `mask_b`, and every other buffer uses `mask_glb`. The per-buffer masks are ignored.
- R3: With the compatibility bit at 0, the lowest-index matching buffer is selected. The new code is 4'b0110 if that buffer's code was full or overrun, and 4'b0010 otherwise.
- R4: With the compatibility bit at 1, each buffer uses its own mask, and the lowest-index matching buffer whose code is 4'b0100 is selected with new code 4'b0010.
- R5: With the compatibility bit at 1, if every matching buffer is full or overrun, the highest-index matching buffer is selected with new code 4'b0110.
- R6: With self-reception disable at 1, a frame tagged as self-transmitted produces neither a store strobe nor an interrupt, whatever matches.
- R7: A frame presented on the clock edge where `rx_valid` is 1 produces its store strobe on the next cycle, for exactly one cycle. A frame with no matching buffer produces no strobe.
- R8: `rx_irq` is high in exactly the cycles in which `st_valid` is high.
- R9: The compatibility and self-reception-disable bits reset to 0. They load from `cfg_compat` and `cfg_selfdis` only on a clock edge where both `cfg_we` and `freeze` are 1. A write without `freeze` has no effect.
- R10: During reset, `st_valid` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Controller frozen; allows configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_compat | input | 1 | Value to write to the compatibility bit |
| cfg_selfdis | input | 1 | Value to write to self-reception disable |
| rx_valid | input | 1 | A received frame is presented this cycle |
| rx_id | input | IDW | Frame identifier; a standard frame uses bits [10:0] |
| rx_ide | input | 1 | Frame is in extended format |
| rx_self | input | 1 | Frame was transmitted by this node |
| buf_id | input | NBUF*IDW | Per-buffer identifiers, buffer i at [i*IDW +: IDW] |
| buf_ide | input | NBUF | Per-buffer IDE flag |
| buf_mask | input | NBUF*IDW | Per-buffer acceptance masks |
| buf_code | input | NBUF*CW | Per-buffer status codes |
| mask_glb | input | IDW | Shared mask in compatibility mode |
| mask_a | input | IDW | Mask of buffer SPEC_A in compatibility mode |
| mask_b | input | IDW | Mask of buffer SPEC_B in compatibility mode |
| st_valid | output | 1 | One-cycle store strobe |
| st_idx | output | $clog2(NBUF) | Index of the selected buffer |
| st_code | output | CW | New status code for the selected buffer |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions check on every cycle that a frame with no match never leads to a store and that a strobe always follows an accepted, non-suppressed frame. They also check that a stored code is always full or overrun, that the interrupt follows the strobe, and that the two configuration bits change only under a frozen write. The choice of buffer cannot be seen by those properties. That includes first-match overwrite against queue skipping, fallback to the highest-index match, use of the dedicated masks for buffers 14 and 15, and the split between standard and extended compares. These choices are shown only by the bench's scenarios, compared against its reference model.

// File: rtl/rxsel_pkg.sv
package rxsel_pkg;
    localparam logic [3:0] CODE_EMPTY   = 4'b0100;
    localparam logic [3:0] CODE_FULL    = 4'b0010;
    localparam logic [3:0] CODE_OVERRUN = 4'b0110;

    function automatic logic is_rx_code(input logic [3:0] c);
        return (c == CODE_EMPTY) || (c == CODE_FULL) || (c == CODE_OVERRUN);
    endfunction

    function automatic logic is_occupied(input logic [3:0] c);
        return (c == CODE_FULL) || (c == CODE_OVERRUN);
    endfunction
endpackage

// File: rtl/mb_match.sv
module mb_match
    import rxsel_pkg::*;
#(
    parameter int NBUF   = 16,
    parameter int IDW    = 29,
    parameter int STDW   = 11,
    parameter int CW     = 4,
    parameter int SPEC_A = 14,
    parameter int SPEC_B = 15
) (
    input  logic [IDW-1:0]      rx_id,
    input  logic                rx_ide,
    input  logic [NBUF*IDW-1:0] buf_id,
    input  logic [NBUF-1:0]     buf_ide,
    input  logic [NBUF*IDW-1:0] buf_mask,
    input  logic [NBUF*CW-1:0]  buf_code,
    input  logic [IDW-1:0]      mask_glb,
    input  logic [IDW-1:0]      mask_a,
    input  logic [IDW-1:0]      mask_b,
    input  logic                compat,
    output logic [NBUF-1:0]     hit,
    output logic [NBUF-1:0]     busy
);
    localparam logic [IDW-1:0] STD_SPAN = {{(IDW-STDW){1'b0}}, {STDW{1'b1}}};

    logic [IDW-1:0] span;
    assign span = rx_ide ? {IDW{1'b1}} : STD_SPAN;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        logic [IDW-1:0] eff_mask;
        logic [CW-1:0]  code;
        assign code = buf_code[i*CW +: CW];
        if (i == SPEC_A) begin : g_a
            assign eff_mask = compat ? buf_mask[i*IDW +: IDW] : mask_a;
        end else if (i == SPEC_B) begin : g_b
            assign eff_mask = compat ? buf_mask[i*IDW +: IDW] : mask_b;
        end else begin : g_n
            assign eff_mask = compat ? buf_mask[i*IDW +: IDW] : mask_glb;
        end
        assign hit[i] = is_rx_code(code) && (buf_ide[i] == rx_ide) &&
                        (((rx_id ^ buf_id[i*IDW +: IDW]) & eff_mask & span) == '0);
        assign busy[i] = is_occupied(code);
    end
endmodule

// File: rtl/pick_scan.sv
module pick_scan #(
    parameter int N       = 16,
    parameter bit FROM_HI = 1'b0,
    localparam int IW     = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    if (FROM_HI) begin : g_hi
        always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < N; i++) begin
                if (vec[i]) begin
                    found = 1'b1;
                    idx   = IW'(i);
                end
            end
        end
    end else begin : g_lo
        always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = N - 1; i >= 0; i--) begin
                if (vec[i]) begin
                    found = 1'b1;
                    idx   = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/rx_slot_selector.sv
module rx_slot_selector
    import rxsel_pkg::*;
#(
    parameter int NBUF   = 16,
    parameter int IDW    = 29,
    parameter int STDW   = 11,
    parameter int CW     = 4,
    parameter int SPEC_A = 14,
    parameter int SPEC_B = 15,
    localparam int IW    = $clog2(NBUF)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                freeze,
    input  logic                cfg_we,
    input  logic                cfg_compat,
    input  logic                cfg_selfdis,
    input  logic                rx_valid,
    input  logic [IDW-1:0]      rx_id,
    input  logic                rx_ide,
    input  logic                rx_self,
    input  logic [NBUF*IDW-1:0] buf_id,
    input  logic [NBUF-1:0]     buf_ide,
    input  logic [NBUF*IDW-1:0] buf_mask,
    input  logic [NBUF*CW-1:0]  buf_code,
    input  logic [IDW-1:0]      mask_glb,
    input  logic [IDW-1:0]      mask_a,
    input  logic [IDW-1:0]      mask_b,
    output logic                st_valid,
    output logic [IW-1:0]       st_idx,
    output logic [CW-1:0]       st_code,
    output logic                rx_irq
);
    typedef struct packed {
        logic          compat;
        logic          selfdis;
        logic          st_valid;
        logic [IW-1:0] st_idx;
        logic [CW-1:0] st_code;
        logic          irq;
    } state_t;

    state_t cur_q, nxt_d;

    logic [NBUF-1:0] hit_v, busy_v, free_v;
    logic            lo_found, hi_found, fr_found;
    logic [IW-1:0]   lo_idx, hi_idx, fr_idx;
    logic            compat_q, selfdis_q;

    assign compat_q  = cur_q.compat;
    assign selfdis_q = cur_q.selfdis;

    mb_match #(
        .NBUF(NBUF), .IDW(IDW), .STDW(STDW), .CW(CW),
        .SPEC_A(SPEC_A), .SPEC_B(SPEC_B)
    ) u_match (
        .rx_id    (rx_id),
        .rx_ide   (rx_ide),
        .buf_id   (buf_id),
        .buf_ide  (buf_ide),
        .buf_mask (buf_mask),
        .buf_code (buf_code),
        .mask_glb (mask_glb),
        .mask_a   (mask_a),
        .mask_b   (mask_b),
        .compat   (compat_q),
        .hit      (hit_v),
        .busy     (busy_v)
    );

    assign free_v = hit_v & ~busy_v;

    pick_scan #(.N(NBUF), .FROM_HI(1'b0)) u_hit_lo (.vec(hit_v),  .found(lo_found), .idx(lo_idx));
    pick_scan #(.N(NBUF), .FROM_HI(1'b1)) u_hit_hi (.vec(hit_v),  .found(hi_found), .idx(hi_idx));
    pick_scan #(.N(NBUF), .FROM_HI(1'b0)) u_free   (.vec(free_v), .found(fr_found), .idx(fr_idx));

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.st_valid = 1'b0;
        nxt_d.irq      = 1'b0;
        if (cfg_we && freeze) begin
            nxt_d.compat  = cfg_compat;
            nxt_d.selfdis = cfg_selfdis;
        end
        if (rx_valid && !(cur_q.selfdis && rx_self)) begin
            if (cur_q.compat) begin
                if (fr_found) begin
                    nxt_d.st_valid = 1'b1;
                    nxt_d.st_idx   = fr_idx;
                    nxt_d.st_code  = CODE_FULL;
                end else if (hi_found) begin
                    nxt_d.st_valid = 1'b1;
                    nxt_d.st_idx   = hi_idx;
                    nxt_d.st_code  = CODE_OVERRUN;
                end
            end else if (lo_found) begin
                nxt_d.st_valid = 1'b1;
                nxt_d.st_idx   = lo_idx;
                nxt_d.st_code  = busy_v[lo_idx] ? CODE_OVERRUN : CODE_FULL;
            end
            nxt_d.irq = nxt_d.st_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st_valid = cur_q.st_valid;
    assign st_idx   = cur_q.st_idx;
    assign st_code  = cur_q.st_code;
    assign rx_irq   = cur_q.irq;
endmodule

// File: rtl/rx_slot_selector_chk.sv
module rx_slot_selector_chk #(
    parameter int NBUF = 16,
    parameter int CW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            freeze,
    input logic            cfg_we,
    input logic            rx_valid,
    input logic            rx_self,
    input logic [NBUF-1:0] hit_vec,
    input logic            compat_q,
    input logic            selfdis_q,
    input logic            st_valid,
    input logic [CW-1:0]   st_code,
    input logic            rx_irq
);
    AST_NO_MATCH_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && hit_vec == '0) |=> !st_valid);  // R7
    AST_SELF_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_self && selfdis_q) |=> !st_valid);  // R6
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> ($past(rx_valid) && !($past(rx_self) && $past(selfdis_q))));  // R7
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_code == 4'b0010 || st_code == 4'b0110));  // R3
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == st_valid);  // R8
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && freeze) |=> ($stable(compat_q) && $stable(selfdis_q)));  // R9
endmodule

bind rx_slot_selector rx_slot_selector_chk #(.NBUF(NBUF), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .cfg_we    (cfg_we),
    .rx_valid  (rx_valid),
    .rx_self   (rx_self),
    .hit_vec   (hit_v),
    .compat_q  (compat_q),
    .selfdis_q (selfdis_q),
    .st_valid  (st_valid),
    .st_code   (st_code),
    .rx_irq    (rx_irq)
);

// File: tb/tb_rx_slot_selector.sv
module tb_rx_slot_selector;
    localparam int NB = 16;
    localparam int IDW = 29;
    localparam int CW = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freeze = 0, cfg_we = 0, cfg_compat = 0, cfg_selfdis = 0;
    logic rx_valid = 0, rx_ide = 0, rx_self = 0;
    logic [IDW-1:0] rx_id = '0;
    logic [IDW-1:0] mask_glb = '1, mask_a = '1, mask_b = '1;
    logic [IDW-1:0] b_id [NB];
    logic [IDW-1:0] b_mask [NB];
    logic [CW-1:0]  b_code [NB];
    logic           b_ide [NB];
    logic [NB*IDW-1:0] buf_id, buf_mask;
    logic [NB*CW-1:0]  buf_code;
    logic [NB-1:0]     buf_ide;
    logic st_valid, rx_irq;
    logic [IW-1:0] st_idx;
    logic [CW-1:0] st_code;

    int compared = 0, mismatched = 0;
    string cur_req = "R10";
    bit done = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            buf_id[i*IDW +: IDW]   = b_id[i];
            buf_mask[i*IDW +: IDW] = b_mask[i];
            buf_code[i*CW +: CW]   = b_code[i];
            buf_ide[i]             = b_ide[i];
        end
    end

    rx_slot_selector dut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_we(cfg_we),
        .cfg_compat(cfg_compat), .cfg_selfdis(cfg_selfdis),
        .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_self(rx_self),
        .buf_id(buf_id), .buf_ide(buf_ide), .buf_mask(buf_mask), .buf_code(buf_code),
        .mask_glb(mask_glb), .mask_a(mask_a), .mask_b(mask_b),
        .st_valid(st_valid), .st_idx(st_idx), .st_code(st_code), .rx_irq(rx_irq)
    );

    // Reference model, evaluated on each rising edge.
    bit m_compat, m_selfdis, e_v;
    int e_idx, e_code;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_compat = 0; m_selfdis = 0; e_v = 0; e_idx = 0; e_code = 0;
        end else begin
            int first, last, free;
            first = -1; last = -1; free = -1;
            e_v = 0;
            if (rx_valid && !(m_selfdis && rx_self)) begin
                for (int i = 0; i < NB; i++) begin
                    logic [IDW-1:0] m, span;
                    bit ok, occ;
                    if (m_compat) m = b_mask[i];
                    else if (i == 14) m = mask_a;
                    else if (i == 15) m = mask_b;
                    else m = mask_glb;
                    span = rx_ide ? {IDW{1'b1}} : IDW'(11'h7FF);
                    occ = (b_code[i] == 4'b0010) || (b_code[i] == 4'b0110);
                    ok = (occ || b_code[i] == 4'b0100) && (b_ide[i] == rx_ide) &&
                         (((rx_id ^ b_id[i]) & m & span) == 0);
                    if (ok) begin
                        if (first < 0) first = i;
                        last = i;
                        if (!occ && free < 0) free = i;
                    end
                end
                if (m_compat) begin
                    if (free >= 0) begin e_v = 1; e_idx = free; e_code = 2; end
                    else if (last >= 0) begin e_v = 1; e_idx = last; e_code = 6; end
                end else if (first >= 0) begin
                    e_v = 1; e_idx = first;
                    e_code = (b_code[first] == 4'b0100) ? 2 : 6;
                end
            end
            if (cfg_we && freeze) begin
                m_compat = cfg_compat; m_selfdis = cfg_selfdis;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        compared++;
        if (st_valid !== e_v || rx_irq !== e_v ||
            (e_v && (int'(st_idx) != e_idx || int'(st_code) != e_code))) begin
            mismatched++;
            $display("FAIL %s: got v=%0b irq=%0b idx=%0d code=%0d, expected v=%0b irq=%0b idx=%0d code=%0d",
                     cur_req, st_valid, rx_irq, st_idx, st_code, e_v, e_v, e_idx, e_code);
        end
    endtask

    task automatic frame(input logic [IDW-1:0] id, input logic ide, input logic self_tx);
        rx_valid = 1; rx_id = id; rx_ide = ide; rx_self = self_tx;
        tick();
        rx_valid = 0; rx_self = 0;
        tick();
        tick();
    endtask

    task automatic cfg(input logic frz, input logic cmp, input logic sd);
        freeze = frz; cfg_we = 1; cfg_compat = cmp; cfg_selfdis = sd;
        tick();
        cfg_we = 0; freeze = 0;
        tick();
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            b_id[i] = '0; b_mask[i] = '1; b_code[i] = 4'b0000; b_ide[i] = 0;
        end
        b_id[0] = 29'h123; b_code[0] = 4'b0100;
        b_id[1] = 29'h123; b_code[1] = 4'b0100;
        b_id[2] = 29'h1ABCDE; b_ide[2] = 1; b_code[2] = 4'b0100;
        b_id[3] = 29'h200; b_mask[3] = 29'h700; b_code[3] = 4'b0100;
        b_id[14] = 29'h050; b_code[14] = 4'b0100;
        b_id[15] = 29'h060; b_code[15] = 4'b0100;
        mask_a = 29'h7F0;
        repeat (3) tick();              // R10 reset state
        rst_n = 1;
        tick();
        // R1 R3: legacy, empty first match
        cur_req = "R3"; frame(29'h123, 0, 0);
        b_code[0] = 4'b0010;
        cur_req = "R3"; frame(29'h123, 0, 0);   // overwrite occupied mb0
        // R2: dedicated mask of buffer 14, global mask blocks buffer 3
        cur_req = "R2"; frame(29'h05A, 0, 0);
        cur_req = "R2"; frame(29'h2FF, 0, 0);
        // R7: no match
        cur_req = "R7"; frame(29'h061, 0, 0);
        // R1: extended compare, IDE must agree
        cur_req = "R1"; frame(29'h1ABCDE, 1, 0);
        cur_req = "R1"; frame(29'h1ABCDE, 0, 0);
        cur_req = "R1"; frame(29'h1FF923, 0, 0);  // standard uses bits [10:0] only
        // R9: compatibility write while frozen
        cur_req = "R9"; cfg(1, 1, 0);
        cur_req = "R4"; frame(29'h123, 0, 0);   // skip full mb0, take mb1
        cur_req = "R4"; frame(29'h2FF, 0, 0);   // per-buffer mask on mb3
        b_code[1] = 4'b0110;
        cur_req = "R5"; frame(29'h123, 0, 0);   // all full -> mb1 overrun
        b_code[1] = 4'b0100;
        // R9: write without freeze is ignored
        cur_req = "R9"; cfg(0, 0, 1);
        cur_req = "R9"; frame(29'h123, 0, 1);
        // R6: self-reception disable
        cur_req = "R6"; cfg(1, 1, 1);
        cur_req = "R6"; frame(29'h123, 0, 1);
        cur_req = "R6"; frame(29'h123, 0, 0);
        cur_req = "R8"; frame(29'h055, 0, 0);
        cur_req = "R10";
        rst_n = 0; tick(); tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule